// File: doc/BRIEF.md
# Write-Back Data Cache, Direct-Mapped

This block is a direct-mapped data cache of 8 KB that sits between a processor's load/store path and a line-transfer bridge. It has 512 lines of four 32-bit words each. Writes stay in the cache until the line is evicted, and a store that misses first brings the line in. A lookup compares the stored tag (address bits [31:12]) of the line selected by address bits [12:4] and checks that line's valid flag. A hit answers in the same cycle as the request.

On a miss, a controller walks through named states. `ST_LOOKUP` is the resting state. It serves hits and detects misses. Every transfer is preceded by a fixed penalty: a dirty victim costs `ST_EVICT_WAIT` (penalty) followed by `ST_EVICT_XFER` (four write beats), and every miss then passes through `ST_FETCH_WAIT` (penalty) and `ST_FETCH_XFER` (four read beats). The transitions are:
- LOOKUP→EVICT_WAIT on a miss with a valid dirty victim.
- LOOKUP→FETCH_WAIT on a miss with a clean or empty victim.
- EVICT_WAIT→EVICT_XFER and FETCH_WAIT→FETCH_XFER when the penalty counter expires.
- EVICT_XFER→FETCH_WAIT on the last acknowledged write beat.
- FETCH_XFER→LOOKUP on the last acknowledged read beat.

Back in LOOKUP the held request now hits and completes. A store completes there by merging its bytes into the fresh line. The processor must hold `cpu_req` and its fields steady until `cpu_ready` pulses.

The burst port presents the line base address on `bm_addr` for the whole burst. Words go in ascending order, from word 0 to word 3, one per cycle in which `bm_ack` is high.

Top module: `dcwb_cache`

## Requirements
- R1: After reset, every line is invalid and clean, so the first access to any address is a miss that performs a fill and no write-back; `cpu_ready` and `bm_req` are low while reset is held.
- R2: An access hits when the indexed line is valid and its tag equals address bits [31:12]; a hit raises `cpu_ready` in the same cycle as `cpu_req`, and a load returns the cached data there.
- R3: An access whose bits [12:4] select a valid line holding a different tag is a miss.
- R4: A miss with no dirty victim issues one read burst at the new line base (address bits [3:0] zero), taking four words in order 0,1,2,3, and `cpu_ready` rises 1+P+4 cycles after the request (P is the penalty, 40 by default, so 45).
- R5: A miss whose victim is valid and dirty first issues a write burst of the victim's four current words at the victim line base, then the read burst; `cpu_ready` rises 1+2(P+4) = 89 cycles after the request.
- R6: A store merges only the bytes whose enables are set and marks the line dirty, so a later eviction writes the merged data back.
- R7: A store miss performs the same evict/fill sequence as a load miss and then merges the store into the filled line, leaving it dirty.
- R8: A fill leaves the line clean, so evicting a line that was loaded but never stored issues no write burst.
- R9: With `cpu_dbl` high the access covers the word pair selected by address bit 3; `cpu_rdata[31:0]` is the even word, `[63:32]` the odd word, and `cpu_be[3:0]`/`[7:4]` enable the bytes of the even/odd word.
- R10: With `cpu_dbl` low the access covers the word at address bits [3:2]; a load returns it in `cpu_rdata[31:0]` with `[63:32]` zero, and a store uses only `cpu_be[3:0]`, ignoring `cpu_be[7:4]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_dbl | input | 1 | 1 = doubleword (word pair) access |
| cpu_addr | input | ADDR_W-2 (30) | Word address, byte address bits [31:2] |
| cpu_wdata | input | 2*WORD_W (64) | Store data |
| cpu_be | input | 2*WORD_W/8 (8) | Store byte enables |
| cpu_rdata | output | 2*WORD_W (64) | Load data, valid with cpu_ready |
| cpu_ready | output | 1 | Access completes this cycle |
| bm_req | output | 1 | Burst active |
| bm_we | output | 1 | 1 = write burst (eviction), 0 = read burst (fill) |
| bm_addr | output | ADDR_W (32) | Line base byte address |
| bm_wdata | output | WORD_W (32) | Current write beat |
| bm_ack | input | 1 | Bridge accepts/delivers the current beat |
| bm_rdata | input | WORD_W (32) | Current read beat |

## Verification
A hit is due in the request cycle itself. A clean miss is due 45 cycles later and a dirty miss 89 cycles later, counting the lookup cycle, both penalty windows and four beats per burst with the bridge acknowledging every beat. The bench predicts which of these latencies applies from its own record of line ownership. In every cycle up to that point it expects `cpu_ready` low, and it expects `cpu_ready` high and the load data correct in exactly the predicted cycle. Each burst beat is compared in the cycle it is presented against a queue of expected direction, address and write-back data built at the time of the request. Every sample is taken a time step after the falling edge, so registered and combinational outputs have settled.

// File: rtl/dcwb_pkg.sv
package dcwb_pkg;

    typedef enum logic [2:0] {
        ST_LOOKUP,
        ST_EVICT_WAIT,
        ST_EVICT_XFER,
        ST_FETCH_WAIT,
        ST_FETCH_XFER
    } dc_state_e;

endpackage

// File: rtl/dcwb_tags.sv
module dcwb_tags #(
    parameter int NUM_LINES = 512,
    parameter int IDX_W     = 9,
    parameter int TAG_W     = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             alloc,
    input  logic [TAG_W-1:0] alloc_tag,
    input  logic             mark_dirty,
    input  logic             clean,
    output logic             line_valid,
    output logic             line_dirty,
    output logic [TAG_W-1:0] line_tag
);

    logic [NUM_LINES-1:0] valid_q;
    logic [NUM_LINES-1:0] dirty_q;
    logic [TAG_W-1:0]     tag_q [NUM_LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (alloc) begin
                valid_q[idx] <= 1'b1;
            end
            if (alloc || clean) begin
                dirty_q[idx] <= 1'b0;
            end else if (mark_dirty) begin
                dirty_q[idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (alloc) begin
            tag_q[idx] <= alloc_tag;
        end
    end

    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];
    assign line_tag   = tag_q[idx];

endmodule

// File: rtl/dcwb_data.sv
module dcwb_data #(
    parameter int NUM_LINES  = 512,
    parameter int IDX_W      = 9,
    parameter int LINE_WORDS = 4,
    parameter int WORD_W     = 32,
    localparam int BE_W      = WORD_W / 8
) (
    input  logic                                 clk,
    input  logic [IDX_W-1:0]                     idx,
    input  logic [LINE_WORDS-1:0][BE_W-1:0]      wr_be,
    input  logic [LINE_WORDS-1:0][WORD_W-1:0]    wr_data,
    output logic [LINE_WORDS-1:0][WORD_W-1:0]    rd_line
);

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
        logic [WORD_W-1:0] bank [NUM_LINES];

        always_ff @(posedge clk) begin
            for (int b = 0; b < BE_W; b++) begin
                if (wr_be[w][b]) begin
                    bank[idx][b*8 +: 8] <= wr_data[w][b*8 +: 8];
                end
            end
        end

        assign rd_line[w] = bank[idx];
    end

endmodule

// File: rtl/dcwb_ctrl.sv
module dcwb_ctrl
    import dcwb_pkg::*;
#(
    parameter int PENALTY    = 40,
    parameter int LINE_WORDS = 4,
    localparam int CNT_W     = $clog2(PENALTY),
    localparam int BEAT_W    = $clog2(LINE_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              hit,
    input  logic              victim_dirty,
    input  logic              bm_ack,
    output logic [BEAT_W-1:0] beat,
    output logic              cpu_ready,
    output logic              bm_req,
    output logic              bm_we,
    output logic              fill_we,
    output logic              fill_done,
    output logic              evict_done
);

    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(PENALTY - 1);
    localparam logic [BEAT_W-1:0] BEAT_LAST = BEAT_W'(LINE_WORDS - 1);

    dc_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BEAT_W-1:0] beat_q;
    logic              last_beat;
    logic              in_xfer;
    logic              in_wait;

    assign last_beat = bm_ack && (beat_q == BEAT_LAST);
    assign in_xfer   = (state_q == ST_EVICT_XFER) || (state_q == ST_FETCH_XFER);
    assign in_wait   = (state_q == ST_EVICT_WAIT) || (state_q == ST_FETCH_WAIT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOKUP: begin
                if (cpu_req && !hit) begin
                    state_d = victim_dirty ? ST_EVICT_WAIT : ST_FETCH_WAIT;
                end
            end
            ST_EVICT_WAIT: begin
                if (cnt_q == CNT_LAST) state_d = ST_EVICT_XFER;
            end
            ST_EVICT_XFER: begin
                if (last_beat) state_d = ST_FETCH_WAIT;
            end
            ST_FETCH_WAIT: begin
                if (cnt_q == CNT_LAST) state_d = ST_FETCH_XFER;
            end
            ST_FETCH_XFER: begin
                if (last_beat) state_d = ST_LOOKUP;
            end
            default: state_d = ST_LOOKUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOOKUP;
            cnt_q   <= '0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (in_wait) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (in_xfer && bm_ack) begin
                beat_q <= (beat_q == BEAT_LAST) ? '0 : beat_q + 1'b1;
            end
        end
    end

    always_comb begin
        cpu_ready  = 1'b0;
        bm_req     = 1'b0;
        bm_we      = 1'b0;
        fill_we    = 1'b0;
        fill_done  = 1'b0;
        evict_done = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                cpu_ready = cpu_req && hit;
            end
            ST_EVICT_XFER: begin
                bm_req     = 1'b1;
                bm_we      = 1'b1;
                evict_done = last_beat;
            end
            ST_FETCH_XFER: begin
                bm_req    = 1'b1;
                fill_we   = bm_ack;
                fill_done = last_beat;
            end
            ST_EVICT_WAIT, ST_FETCH_WAIT: begin
            end
            default: begin
            end
        endcase
    end

    assign beat = beat_q;

endmodule

// File: rtl/dcwb_cache.sv
module dcwb_cache #(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int NUM_LINES  = 512,
    parameter int TAG_LSB    = 12,
    parameter int PENALTY    = 40,
    localparam int BE_W      = WORD_W / 8,
    localparam int BYTE_OFF  = $clog2(BE_W),
    localparam int WSEL_W    = $clog2(LINE_WORDS),
    localparam int OFF_W     = BYTE_OFF + WSEL_W,
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int TAG_W     = ADDR_W - TAG_LSB
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cpu_req,
    input  logic                       cpu_we,
    input  logic                       cpu_dbl,
    input  logic [ADDR_W-1:BYTE_OFF]   cpu_addr,
    input  logic [2*WORD_W-1:0]        cpu_wdata,
    input  logic [2*BE_W-1:0]          cpu_be,
    output logic [2*WORD_W-1:0]        cpu_rdata,
    output logic                       cpu_ready,
    output logic                       bm_req,
    output logic                       bm_we,
    output logic [ADDR_W-1:0]          bm_addr,
    output logic [WORD_W-1:0]          bm_wdata,
    input  logic                       bm_ack,
    input  logic [WORD_W-1:0]          bm_rdata
);

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  req_tag;
    logic [WSEL_W-1:0] wsel;
    logic [WSEL_W-1:0] pair_lo;
    logic [WSEL_W-1:0] pair_hi;

    assign idx     = cpu_addr[OFF_W +: IDX_W];
    assign req_tag = cpu_addr[ADDR_W-1:TAG_LSB];
    assign wsel    = cpu_addr[BYTE_OFF +: WSEL_W];
    assign pair_lo = {wsel[WSEL_W-1:1], 1'b0};
    assign pair_hi = {wsel[WSEL_W-1:1], 1'b1};

    logic              line_valid;
    logic              line_dirty;
    logic [TAG_W-1:0]  line_tag;
    logic              hit;
    logic              victim_dirty;
    logic [WSEL_W-1:0] beat;
    logic              fill_we;
    logic              fill_done;
    logic              evict_done;
    logic              store_commit;

    logic [LINE_WORDS-1:0][BE_W-1:0]   wr_be;
    logic [LINE_WORDS-1:0][WORD_W-1:0] wr_data;
    logic [LINE_WORDS-1:0][WORD_W-1:0] rd_line;

    assign hit          = line_valid && (line_tag == req_tag);
    assign victim_dirty = line_valid && line_dirty;
    assign store_commit = cpu_ready && cpu_we;

    dcwb_tags #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W),
        .TAG_W     (TAG_W)
    ) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (idx),
        .alloc      (fill_done),
        .alloc_tag  (req_tag),
        .mark_dirty (store_commit),
        .clean      (evict_done),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag)
    );

    dcwb_data #(
        .NUM_LINES  (NUM_LINES),
        .IDX_W      (IDX_W),
        .LINE_WORDS (LINE_WORDS),
        .WORD_W     (WORD_W)
    ) u_data (
        .clk     (clk),
        .idx     (idx),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .rd_line (rd_line)
    );

    dcwb_ctrl #(
        .PENALTY    (PENALTY),
        .LINE_WORDS (LINE_WORDS)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .hit          (hit),
        .victim_dirty (victim_dirty),
        .bm_ack       (bm_ack),
        .beat         (beat),
        .cpu_ready    (cpu_ready),
        .bm_req       (bm_req),
        .bm_we        (bm_we),
        .fill_we      (fill_we),
        .fill_done    (fill_done),
        .evict_done   (evict_done)
    );

    // Data array write port: fill beats or a merged store.
    always_comb begin
        wr_be   = '0;
        wr_data = '0;
        if (fill_we) begin
            wr_be[beat]   = '1;
            wr_data[beat] = bm_rdata;
        end else if (store_commit) begin
            if (cpu_dbl) begin
                wr_be[pair_lo]   = cpu_be[BE_W-1:0];
                wr_data[pair_lo] = cpu_wdata[WORD_W-1:0];
                wr_be[pair_hi]   = cpu_be[2*BE_W-1:BE_W];
                wr_data[pair_hi] = cpu_wdata[2*WORD_W-1:WORD_W];
            end else begin
                wr_be[wsel]   = cpu_be[BE_W-1:0];
                wr_data[wsel] = cpu_wdata[WORD_W-1:0];
            end
        end
    end

    assign cpu_rdata = cpu_dbl ? {rd_line[pair_hi], rd_line[pair_lo]}
                               : {{WORD_W{1'b0}}, rd_line[wsel]};

    logic [ADDR_W-1:0] victim_base;
    logic [ADDR_W-1:0] fetch_base;

    assign victim_base = {line_tag, {TAG_LSB{1'b0}}}
                       | {{(ADDR_W-IDX_W-OFF_W){1'b0}}, idx, {OFF_W{1'b0}}};
    assign fetch_base  = {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    assign bm_addr  = bm_we ? victim_base : fetch_base;
    assign bm_wdata = rd_line[beat];

endmodule

// File: rtl/dcwb_cache_chk.sv
module dcwb_cache_chk #(
    parameter int PENALTY    = 40,
    parameter int LINE_WORDS = 4,
    parameter int ADDR_W     = 32,
    localparam int GAP_W     = $clog2(PENALTY + 1),
    localparam int BCNT_W    = $clog2(LINE_WORDS) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic              bm_req,
    input logic              bm_we,
    input logic [ADDR_W-1:0] bm_addr,
    input logic              bm_ack
);

    logic [GAP_W-1:0]  gap_cnt;
    logic [BCNT_W-1:0] beat_cnt;
    logic              last_was_write;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt        <= '0;
            beat_cnt       <= '0;
            last_was_write <= 1'b0;
        end else begin
            if (bm_req) begin
                gap_cnt <= '0;
            end else if (gap_cnt != GAP_W'(PENALTY)) begin
                gap_cnt <= gap_cnt + 1'b1;
            end
            if (!bm_req) begin
                beat_cnt <= '0;
            end else if (bm_ack) begin
                beat_cnt <= beat_cnt + 1'b1;
            end
            if (bm_req) begin
                last_was_write <= bm_we;
            end
        end
    end

    // R2: completion only answers a pending request
    a_r2_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req);

    // R4: a burst keeps its address and direction for its whole length
    a_r4_burst_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_req && $past(bm_req)) |-> ($stable(bm_addr) && $stable(bm_we)));

    // R4: no more than one line of beats per burst
    a_r4_beat_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (bm_req && bm_ack) |-> (beat_cnt < BCNT_W'(LINE_WORDS)));

    // R5: every burst is preceded by the full penalty window
    a_r5_penalty_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bm_req) |-> (gap_cnt >= GAP_W'(PENALTY)));

    // R5: an eviction burst is always followed by a fill burst
    a_r5_fill_after_evict: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bm_req) && last_was_write) |-> !bm_we);

endmodule

bind dcwb_cache dcwb_cache_chk #(
    .PENALTY    (PENALTY),
    .LINE_WORDS (LINE_WORDS),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_ready (cpu_ready),
    .bm_req    (bm_req),
    .bm_we     (bm_we),
    .bm_addr   (bm_addr),
    .bm_ack    (bm_ack)
);

// File: tb/dcwb_cache_test.sv
module dcwb_cache_test;

    localparam int CLK_PERIOD = 10;
    localparam int LAT_CLEAN  = 45;
    localparam int LAT_DIRTY  = 89;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic        cpu_dbl = 1'b0;
    logic [31:0] cpu_baddr = '0;
    logic [63:0] cpu_wdata = '0;
    logic [7:0]  cpu_be = '0;
    logic [63:0] cpu_rdata;
    logic        cpu_ready;
    logic        bm_req;
    logic        bm_we;
    logic [31:0] bm_addr;
    logic [31:0] bm_wdata;
    logic        bm_ack = 1'b1;
    logic [31:0] bm_rdata = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcwb_cache uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_dbl   (cpu_dbl),
        .cpu_addr  (cpu_baddr[31:2]),
        .cpu_wdata (cpu_wdata),
        .cpu_be    (cpu_be),
        .cpu_rdata (cpu_rdata),
        .cpu_ready (cpu_ready),
        .bm_req    (bm_req),
        .bm_we     (bm_we),
        .bm_addr   (bm_addr),
        .bm_wdata  (bm_wdata),
        .bm_ack    (bm_ack),
        .bm_rdata  (bm_rdata)
    );

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 0;

    // Behavioural model: line ownership, coherent memory view, backing store.
    bit          m_valid [int];
    bit          m_dirty [int];
    logic [19:0] m_tag   [int];
    logic [31:0] gold    [int];
    logic [31:0] bmem    [int];

    logic        exp_we_q   [$];
    logic [31:0] exp_addr_q [$];
    logic [31:0] exp_data_q [$];

    function automatic logic [31:0] seed_word(logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h3C3C_0F0F;
    endfunction

    function automatic logic [31:0] gold_rd(logic [31:0] a);
        return gold.exists(int'(a)) ? gold[int'(a)] : seed_word(a);
    endfunction

    function automatic logic [31:0] bmem_rd(logic [31:0] a);
        return bmem.exists(int'(a)) ? bmem[int'(a)] : seed_word(a);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Burst monitor / bridge model: one beat per cycle while bm_req is high.
    int          bcnt = 0;
    logic [31:0] mon_a;
    logic        mon_we;
    logic [31:0] mon_ea;
    logic [31:0] mon_ed;

    always @(negedge clk) begin
        if (rst_n && bm_req) begin
            mon_a = bm_addr + 32'(bcnt * 4);
            if (exp_addr_q.size() == 0) begin
                check(1'b0, "R8", "unexpected burst beat", {32'b0, mon_a}, 64'b0);
            end else begin
                mon_we = exp_we_q.pop_front();
                mon_ea = exp_addr_q.pop_front();
                mon_ed = exp_data_q.pop_front();
                check(bm_we == mon_we, "R5", "burst direction", {63'b0, bm_we}, {63'b0, mon_we});
                check(mon_a == mon_ea, "R4", "beat address", {32'b0, mon_a}, {32'b0, mon_ea});
                if (mon_we) begin
                    check(bm_wdata == mon_ed, "R6", "write-back word",
                          {32'b0, bm_wdata}, {32'b0, mon_ed});
                    bmem[int'(mon_a)] = bm_wdata;
                end
            end
            bm_rdata = bmem_rd(mon_a);
            bcnt++;
        end else begin
            bcnt = 0;
        end
    end

    // One access, started and finished at a falling edge.
    task automatic access(input logic [31:0] a, input bit we, input bit dbl,
                          input logic [7:0] be, input logic [63:0] wd, input string req);
        int          idx;
        logic [19:0] t;
        bit          hit;
        int          lat;
        logic [31:0] vbase;
        logic [31:0] nbase;
        logic [31:0] pb;
        logic [31:0] wa;
        logic [63:0] exp_rd;
        logic [31:0] w;
        idx = int'(a[12:4]);
        t   = a[31:12];
        hit = m_valid.exists(idx) && m_valid[idx] && (m_tag[idx] == t);
        lat = 0;
        if (!hit) begin
            if (m_valid.exists(idx) && m_valid[idx] && m_dirty[idx]) begin
                vbase = {m_tag[idx], 12'b0} | (32'(idx) << 4);
                for (int i = 0; i < 4; i++) begin
                    exp_we_q.push_back(1'b1);
                    exp_addr_q.push_back(vbase + 32'(4*i));
                    exp_data_q.push_back(gold_rd(vbase + 32'(4*i)));
                end
                lat = LAT_DIRTY;
            end else begin
                lat = LAT_CLEAN;
            end
            nbase = {a[31:4], 4'b0};
            for (int i = 0; i < 4; i++) begin
                exp_we_q.push_back(1'b0);
                exp_addr_q.push_back(nbase + 32'(4*i));
                exp_data_q.push_back(32'b0);
            end
            m_valid[idx] = 1'b1;
            m_tag[idx]   = t;
            m_dirty[idx] = 1'b0;
        end
        pb = {a[31:3], 3'b0};
        wa = {a[31:2], 2'b0};
        exp_rd = dbl ? {gold_rd(pb + 32'd4), gold_rd(pb)} : {32'b0, gold_rd(wa)};

        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_dbl   = dbl;
        cpu_baddr = a;
        cpu_be    = be;
        cpu_wdata = wd;
        for (int k = 0; k <= lat; k++) begin
            #1;
            if (k < lat) begin
                if (cpu_ready) begin
                    check(1'b0, req, "ready before due cycle", 64'(k), 64'(lat));
                end
                @(negedge clk);
            end else begin
                check(cpu_ready == 1'b1, req, "ready in due cycle", {63'b0, cpu_ready}, 64'd1);
                if (!we) begin
                    check(cpu_rdata == exp_rd, req, "load data", cpu_rdata, exp_rd);
                end
            end
        end
        @(negedge clk);
        cpu_req = 1'b0;
        cpu_we  = 1'b0;

        if (we) begin
            m_dirty[idx] = 1'b1;
            for (int b = 0; b < 8; b++) begin
                if (be[b] && (dbl || b < 4)) begin
                    wa = dbl ? pb + ((b >= 4) ? 32'd4 : 32'd0) : {a[31:2], 2'b0};
                    w  = gold_rd(wa);
                    w[(b%4)*8 +: 8] = wd[b*8 +: 8];
                    gold[int'(wa)] = w;
                end
            end
        end
    endtask

    int unsigned lcg;

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(cpu_ready == 1'b0, "R1", "ready low in reset", {63'b0, cpu_ready}, 64'b0);
        check(bm_req == 1'b0, "R1", "burst idle in reset", {63'b0, bm_req}, 64'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R4: first access misses, clean fill only
        access(32'h0000_1234, 1'b0, 1'b0, 8'h00, 64'h0, "R1");
        // R2: other word of the same line hits
        access(32'h0000_1238, 1'b0, 1'b0, 8'h00, 64'h0, "R2");
        // R6: partial store hit, then read back
        access(32'h0000_1234, 1'b1, 1'b0, 8'h06, 64'h0000_0000_AABB_CCDD, "R6");
        access(32'h0000_1234, 1'b0, 1'b0, 8'h00, 64'h0, "R6");
        // R9: doubleword load and store of the upper pair
        access(32'h0000_1238, 1'b0, 1'b1, 8'h00, 64'h0, "R9");
        access(32'h0000_1238, 1'b1, 1'b1, 8'hF1, 64'h1122_3344_5566_7788, "R9");
        access(32'h0000_123C, 1'b0, 1'b0, 8'h00, 64'h0, "R9");
        // R10: word store with only upper enables writes nothing
        access(32'h0000_1230, 1'b1, 1'b0, 8'hF0, 64'hDEAD_BEEF_DEAD_BEEF, "R10");
        access(32'h0000_1230, 1'b0, 1'b0, 8'h00, 64'h0, "R10");
        // R3/R5: same index, other tag, dirty victim written back
        access(32'h0000_3234, 1'b0, 1'b0, 8'h00, 64'h0, "R3");
        // R8: the filled line is clean, so going back costs only a fill
        access(32'h0000_1230, 1'b0, 1'b1, 8'h00, 64'h0, "R8");
        // R7: store miss, then eviction carries the stored bytes
        access(32'h0004_5678, 1'b1, 1'b0, 8'h0F, 64'h0000_0000_CAFE_F00D, "R7");
        access(32'h0004_5678, 1'b0, 1'b0, 8'h00, 64'h0, "R7");
        access(32'h0004_7670, 1'b0, 1'b0, 8'h00, 64'h0, "R5");
        access(32'h0004_5678, 1'b0, 1'b0, 8'h00, 64'h0, "R7");

        // Mixed traffic over a few indices and two tags
        lcg = 32'h1234_5678;
        for (int n = 0; n < 48; n++) begin
            logic [31:0] a;
            lcg = lcg * 32'd1103515245 + 32'd12345;
            a = 32'h0010_0000 | (lcg[20] ? 32'h2000 : 32'h0)
              | (32'(lcg[22:21]) << 4) | (32'(lcg[24:23]) << 2);
            access(a, lcg[25], lcg[26], lcg[15:8], {lcg, ~lcg}, lcg[26] ? "R9" : "R10");
        end

        repeat (2) @(negedge clk);
        check(exp_addr_q.size() == 0, "R5", "all predicted beats seen",
              64'(exp_addr_q.size()), 64'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL R1 watchdog expired: actual=%h expected=%h", 64'd0, 64'd1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule